// File: doc/BRIEF.md
# CAN Reset and Bus-Off Recovery Controller

This block orders the resets of a standalone CAN controller. Three things can reset the controller. The first is an active-low hardware reset pin. The second is a register write that sets both the reset bit and the initialization bit, which is the hard software reset. The third is a write that sets the reset bit with the initialization bit clear, which is the soft software reset.

The block works out which reset applies and drives the following outputs:
- one-cycle clear strobes for the request registers held elsewhere (receive-ready, transmit-request and remote-request-pending);
- a one-cycle bus-halt strobe;
- an error-counter clear.

It also holds the bus-off state and runs recovery from it. It sees only a per-bit sample strobe and the sampled bus level, where 1 means recessive. Eleven recessive samples in a row make one idle phase. After a soft reset taken while bus-off, the controller leaves bus-off only once 128 idle phases have been counted. A receive-status bit reports reception and the synchronization that follows any reset.

Top module: `can_rst_ctrl`

## Requirements
- R1: While `hw_rst_n` is low: `err_clr_o`=1, `rx_status_o`=1, `bus_off_o`=0, `reg_rst_o`=1, `reg_init_o`=1, `clr_req_o`=0. After `hw_rst_n` rises, `err_clr_o` stays 1 for the first rising clock edge and drops at the second.
- R2: A write (`ctl_wr_i`=1) with `ctl_rst_i`=1 and `ctl_init_i`=1 is a hard software reset. `clr_req_o`, `halt_bus_o` and `err_clr_o` are then each 1 for exactly the one cycle after the write edge.
- R3: A write with `ctl_rst_i`=1 and `ctl_init_i`=0 is a soft software reset. `clr_req_o` and `halt_bus_o` are then 1 for exactly the one cycle after the write edge, and `err_clr_o` stays 0.
- R4: A write with `ctl_rst_i`=0 produces no strobe on `clr_req_o`, `halt_bus_o` or `err_clr_o`.
- R5: `reg_rst_o` and `reg_init_o` hold the values of the last write. Neither kind of software reset alters them.
- R6: An idle phase is 11 consecutive samples (`bit_tick_i`=1) with `rx_bit_i`=1. A sample with `rx_bit_i`=0 restarts the count, and any reset restarts it too.
- R7: After any reset, `rx_status_o` is 1 until the first idle phase completes. It becomes 0 on the edge of that phase's eleventh sample, provided the bus is not receiving.
- R8: Outside synchronization, `rx_status_o` = `rx_active_i` AND NOT `tx_active_i`.
- R9: A cycle with `busoff_set_i`=1 sets `bus_off_o` on the next edge. It stays 1 without a reset, whatever the bus traffic.
- R10: A soft reset taken while bus-off starts recovery. `bus_off_o` falls on the edge of the 11th recessive sample of the 128th idle phase counted after the reset, and not before. A soft reset taken while not bus-off leaves `bus_off_o` at 0.
- R11: A hard software reset clears `bus_off_o` one edge after its strobe cycle, with no idle phases needed.
- R12: A hardware reset takes priority over a register write in the same cycles. Writes made while `hw_rst_n` is low give no strobe, and the register bits read 1,1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_rst_i | input | 1 | Written reset bit |
| ctl_init_i | input | 1 | Written initialization-mode bit |
| bit_tick_i | input | 1 | One-cycle strobe per sampled CAN bit |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| rx_active_i | input | 1 | Protocol engine is receiving a frame |
| tx_active_i | input | 1 | Protocol engine is transmitting a frame |
| busoff_set_i | input | 1 | Error logic requests entry to bus-off |
| reg_rst_o | output | 1 | Reset bit readback |
| reg_init_o | output | 1 | Initialization bit readback |
| clr_req_o | output | 1 | Clear strobe for receive-ready, transmit-request and remote-pending registers |
| halt_bus_o | output | 1 | Abort-all-bus-activity strobe |
| err_clr_o | output | 1 | Clear for transmit and receive error counters |
| bus_off_o | output | 1 | Bus-off state |
| rx_status_o | output | 1 | Receiving or synchronizing |

## Verification
The assertions assume several things about the inputs:
- every input is a defined 0 or 1 from the first clock edge after reset release;
- `busoff_set_i` is never raised in the same cycle as a reset strobe;
- `bit_tick_i` lasts one clock per sample.

The stimulus drives every input to a known value at time zero and changes inputs only on falling clock edges. It keeps sample ticks off the strobe cycle of each software reset, so the effect of the reset is never masked by a count in the same cycle. Bus-off entry is requested only while no reset strobe is pending.

// File: rtl/can_rst_pkg.sv
package can_rst_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_SOFT = 2'd1,
    RK_HARD = 2'd2
  } rst_kind_e;

  function automatic rst_kind_e classify_write(input logic wr, input logic rbit, input logic ibit);
    rst_kind_e k;
    k = RK_NONE;
    if (wr && rbit) begin
      k = ibit ? RK_HARD : RK_SOFT;
    end
    return k;
  endfunction

endpackage

// File: rtl/can_rst_sync.sv
module can_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/can_rst_decode.sv
module can_rst_decode
  import can_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_rst,
  input  logic ctl_init,
  output logic reg_rst,
  output logic reg_init,
  output logic soft_p,
  output logic hard_p
);

  rst_kind_e  kind_d, kind_q;
  logic [1:0] bits_d, bits_q;

  always_comb begin
    kind_d = classify_write(ctl_wr, ctl_rst, ctl_init);
    bits_d = bits_q;
    if (ctl_wr) bits_d = {ctl_rst, ctl_init};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RK_NONE;
      bits_q <= 2'b11;
    end else begin
      kind_q <= kind_d;
      bits_q <= bits_d;
    end
  end

  assign soft_p   = (kind_q == RK_SOFT);
  assign hard_p   = (kind_q == RK_HARD);
  assign reg_rst  = bits_q[1];
  assign reg_init = bits_q[0];

  assert_soft_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_p |-> $past(ctl_wr && ctl_rst && !ctl_init));

  assert_hard_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hard_p |-> $past(ctl_wr && ctl_rst && ctl_init));

  assert_no_strobe_without_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(ctl_wr && ctl_rst)) |-> !(soft_p || hard_p));

  assert_bits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl_wr) |-> $stable({reg_rst, reg_init}));

endmodule

// File: rtl/can_idle_phase_cnt.sv
module can_idle_phase_cnt #(
  parameter int RUN_LEN = 11,
  parameter int PHASES  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_run,
  input  logic clr_phase,
  input  logic tick,
  input  logic rx_rec,
  input  logic phase_en,
  output logic idle_evt,
  output logic phases_done
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int PH_W  = $clog2(PHASES);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);

  logic [RUN_W-1:0] run_d, run_q;
  logic [PH_W-1:0]  ph_d, ph_q;
  logic             run_full;
  logic             ph_full;

  assign run_full    = (run_q == RUN_LAST);
  assign ph_full     = (ph_q == PH_LAST);
  assign idle_evt    = !clr_run && tick && rx_rec && run_full;
  assign phases_done = !clr_phase && phase_en && idle_evt && ph_full;

  always_comb begin
    run_d = run_q;
    if (clr_run) begin
      run_d = '0;
    end else if (tick) begin
      if (!rx_rec || run_full) run_d = '0;
      else                     run_d = run_q + 1'b1;
    end
  end

  always_comb begin
    ph_d = ph_q;
    if (clr_phase) begin
      ph_d = '0;
    end else if (phase_en && idle_evt) begin
      if (ph_full) ph_d = '0;
      else         ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ph_q  <= '0;
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
    end
  end

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST);

  assert_dominant_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !rx_rec) |-> (run_q == '0));

  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!phase_en && !clr_phase) |-> $stable(ph_q));

endmodule

// File: rtl/can_rst_ctrl.sv
module can_rst_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 11,
  parameter int PHASES      = 128
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic ctl_wr_i,
  input  logic ctl_rst_i,
  input  logic ctl_init_i,
  input  logic bit_tick_i,
  input  logic rx_bit_i,
  input  logic rx_active_i,
  input  logic tx_active_i,
  input  logic busoff_set_i,
  output logic reg_rst_o,
  output logic reg_init_o,
  output logic clr_req_o,
  output logic halt_bus_o,
  output logic err_clr_o,
  output logic bus_off_o,
  output logic rx_status_o
);

  logic rst_n_s;
  logic soft_p, hard_p;
  logic idle_evt, phases_done;
  logic sync_d, sync_q;
  logic boff_d, boff_q;
  logic recov_d, recov_q;
  logic any_sw;

  can_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .arst_n (hw_rst_n),
    .srst_n (rst_n_s)
  );

  can_rst_decode i_decode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ctl_wr   (ctl_wr_i),
    .ctl_rst  (ctl_rst_i),
    .ctl_init (ctl_init_i),
    .reg_rst  (reg_rst_o),
    .reg_init (reg_init_o),
    .soft_p   (soft_p),
    .hard_p   (hard_p)
  );

  assign any_sw = soft_p || hard_p;

  can_idle_phase_cnt #(.RUN_LEN(RUN_LEN), .PHASES(PHASES)) i_idle (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .clr_run     (any_sw),
    .clr_phase   (any_sw || busoff_set_i),
    .tick        (bit_tick_i),
    .rx_rec      (rx_bit_i),
    .phase_en    (recov_q),
    .idle_evt    (idle_evt),
    .phases_done (phases_done)
  );

  always_comb begin
    sync_d = sync_q;
    if (any_sw)        sync_d = 1'b1;
    else if (idle_evt) sync_d = 1'b0;
  end

  always_comb begin
    boff_d  = boff_q;
    recov_d = recov_q;
    if (hard_p) begin
      boff_d  = 1'b0;
      recov_d = 1'b0;
    end else if (busoff_set_i) begin
      boff_d  = 1'b1;
      recov_d = 1'b0;
    end else if (soft_p) begin
      recov_d = boff_q;
    end else if (phases_done) begin
      boff_d  = 1'b0;
      recov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sync_q  <= 1'b1;
      boff_q  <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      boff_q  <= boff_d;
      recov_q <= recov_d;
    end
  end

  assign clr_req_o   = any_sw;
  assign halt_bus_o  = any_sw;
  assign err_clr_o   = hard_p || !rst_n_s;
  assign bus_off_o   = boff_q;
  assign rx_status_o = sync_q || (rx_active_i && !tx_active_i);

  assert_busoff_rise_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(boff_q) |-> $past(busoff_set_i));

  assert_busoff_fall_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(boff_q) |-> $past(hard_p || (recov_q && bit_tick_i && rx_bit_i)));

  assert_sync_end_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(sync_q) |-> $past(bit_tick_i && rx_bit_i && !any_sw));

  assert_soft_keeps_errs_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_p |-> !err_clr_o);

endmodule

// File: tb/test_can_rst_ctrl.sv
module test_can_rst_ctrl;

  logic clk;
  logic hw_rst_n;
  logic ctl_wr_i, ctl_rst_i, ctl_init_i;
  logic bit_tick_i, rx_bit_i;
  logic rx_active_i, tx_active_i, busoff_set_i;
  logic reg_rst_o, reg_init_o, clr_req_o, halt_bus_o, err_clr_o, bus_off_o, rx_status_o;

  int n_chk;
  int n_fail;
  bit done;

  can_rst_ctrl i_can_rst_ctrl (
    .clk          (clk),
    .hw_rst_n     (hw_rst_n),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_rst_i    (ctl_rst_i),
    .ctl_init_i   (ctl_init_i),
    .bit_tick_i   (bit_tick_i),
    .rx_bit_i     (rx_bit_i),
    .rx_active_i  (rx_active_i),
    .tx_active_i  (tx_active_i),
    .busoff_set_i (busoff_set_i),
    .reg_rst_o    (reg_rst_o),
    .reg_init_o   (reg_init_o),
    .clr_req_o    (clr_req_o),
    .halt_bus_o   (halt_bus_o),
    .err_clr_o    (err_clr_o),
    .bus_off_o    (bus_off_o),
    .rx_status_o  (rx_status_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // write vectors: {rst bit, init bit, expect clear strobe, expect error clear}
  localparam int NVEC = 6;
  localparam logic [3:0] WR_VEC [NVEC] = '{
    4'b0000, 4'b1010, 4'b0100, 4'b1111, 4'b1010, 4'b0000
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bits(input logic v, input int n);
    bit_tick_i = 1'b1;
    rx_bit_i   = v;
    repeat (n) @(negedge clk);
    bit_tick_i = 1'b0;
    rx_bit_i   = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    hw_rst_n = 1'b0;
    ctl_wr_i = 1'b0; ctl_rst_i = 1'b0; ctl_init_i = 1'b0;
    bit_tick_i = 1'b0; rx_bit_i = 1'b1;
    rx_active_i = 1'b0; tx_active_i = 1'b0; busoff_set_i = 1'b0;

    repeat (2) @(negedge clk);
    // R12: soft-reset write while the pin holds reset
    ctl_wr_i = 1'b1; ctl_rst_i = 1'b1; ctl_init_i = 1'b0;
    @(negedge clk);
    check("R12 strobe in reset", clr_req_o, 1'b0);
    ctl_wr_i = 1'b0; ctl_rst_i = 1'b0;
    @(negedge clk);
    check("R1 err_clr", err_clr_o, 1'b1);
    check("R1 rx_status", rx_status_o, 1'b1);
    check("R1 bus_off", bus_off_o, 1'b0);
    check("R1 reg_rst", reg_rst_o, 1'b1);
    check("R1 reg_init", reg_init_o, 1'b1);

    hw_rst_n = 1'b1;
    @(negedge clk);
    check("R1 err_clr after one edge", err_clr_o, 1'b1);
    @(negedge clk);
    check("R1 err_clr after two edges", err_clr_o, 1'b0);
    check("R12 reg bits after release", reg_rst_o & reg_init_o, 1'b1);
    check("R12 no strobe after release", clr_req_o, 1'b0);

    // R6/R7: dominant bit restarts the run, sync ends on 11th recessive
    send_bits(1'b1, 10);
    send_bits(1'b0, 1);
    send_bits(1'b1, 10);
    check("R6 run restarted by dominant", rx_status_o, 1'b1);
    send_bits(1'b1, 1);
    check("R7 sync ends after idle phase", rx_status_o, 1'b0);

    // R8: status from activity inputs
    for (int k = 0; k < 4; k++) begin
      rx_active_i = k[0];
      tx_active_i = k[1];
      #1;
      check("R8 rx_status", rx_status_o, k[0] & ~k[1]);
    end
    rx_active_i = 1'b0; tx_active_i = 1'b0;

    // R2/R3/R4/R5/R7: table of register writes
    for (int v = 0; v < NVEC; v++) begin
      ctl_wr_i = 1'b1; ctl_rst_i = WR_VEC[v][3]; ctl_init_i = WR_VEC[v][2];
      @(negedge clk);
      ctl_wr_i = 1'b0;
      check("R2/R3/R4 clr_req pulse", clr_req_o, WR_VEC[v][1]);
      check("R2/R3/R4 halt_bus pulse", halt_bus_o, WR_VEC[v][1]);
      check("R2/R3 err_clr pulse", err_clr_o, WR_VEC[v][0]);
      @(negedge clk);
      check("R2/R3 strobe one cycle", clr_req_o | halt_bus_o | err_clr_o, 1'b0);
      check("R5 reg_rst", reg_rst_o, WR_VEC[v][3]);
      check("R5 reg_init", reg_init_o, WR_VEC[v][2]);
      if (WR_VEC[v][1]) check("R7 sync after sw reset", rx_status_o, 1'b1);
      check("R10 soft reset not bus-off", bus_off_o, 1'b0);
    end
    send_bits(1'b1, 11);
    check("R7 sync cleared", rx_status_o, 1'b0);

    // R9: bus-off entry and hold
    busoff_set_i = 1'b1;
    @(negedge clk);
    busoff_set_i = 1'b0;
    check("R9 bus_off set", bus_off_o, 1'b1);
    send_bits(1'b1, 40);
    check("R9 bus_off held", bus_off_o, 1'b1);

    // R10: soft reset recovery after 128 idle phases
    ctl_wr_i = 1'b1; ctl_rst_i = 1'b1; ctl_init_i = 1'b0;
    @(negedge clk);
    ctl_wr_i = 1'b0;
    @(negedge clk);
    check("R10 still bus-off after soft reset", bus_off_o, 1'b1);
    send_bits(1'b1, 127 * 11 + 10);
    check("R10 bus_off before last bit", bus_off_o, 1'b1);
    send_bits(1'b1, 1);
    check("R10 bus_off recovered", bus_off_o, 1'b0);

    // R11: hard software reset clears bus-off immediately
    busoff_set_i = 1'b1;
    @(negedge clk);
    busoff_set_i = 1'b0;
    check("R9 bus_off set again", bus_off_o, 1'b1);
    ctl_wr_i = 1'b1; ctl_rst_i = 1'b1; ctl_init_i = 1'b1;
    @(negedge clk);
    ctl_wr_i = 1'b0;
    check("R11 err_clr on hard reset", err_clr_o, 1'b1);
    @(negedge clk);
    check("R11 bus_off cleared", bus_off_o, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule